// File: doc/BRIEF.md
# Wavelet Coefficient Thresholding Compressor

This block compresses one frame of 48 signed 16-bit wavelet coefficients. A coefficient survives only when its magnitude reaches a threshold amplitude supplied with the frame. Every surviving coefficient is scaled by the frame's peak amplitude and reduced to a 6-bit code. The code is the sign followed by a 5-bit fraction of magnitude over peak. Discarded coefficients leave no value behind. Their absence is recorded in a 48-bit position map.

The frame arrives as a stream of one coefficient per valid beat. The threshold and the peak ride on the first beat, which is marked by a start flag. Both are computed upstream. Once the 48th coefficient has been seen, the block emits a one-cycle map strobe. The strobe carries the position map and the peak at its full 16-bit width, so that a decoder can rebuild amplitudes. The 6-bit codes then follow in index order, one every five cycles, produced by a bit-serial restoring divider. A last flag marks the final code. While a frame is in flight the block reports busy. A new frame may begin once busy is low.

Top module: `wcomp_top`

## Requirements
- R1: A beat with `in_valid` and `in_start` both high while `busy` is low opens a frame. That beat carries index 0 and latches `in_thr` and `in_cmax`. The next 47 beats with `in_valid` high carry indices 1 to 47 in order. `busy` is high from the cycle after the start beat until the last code is presented, or until the map strobe when nothing is kept.
- R2: A coefficient is kept exactly when its magnitude is greater than or equal to the latched threshold. A magnitude equal to the threshold is kept and one below it is not. The magnitude of -32768 is taken as 32768.
- R3: One cycle after the 48th beat, `map_valid` is high for exactly one cycle. At the same time `map` bit i is 1 if and only if the coefficient at index i was kept, and `cmax_out` equals the latched peak.
- R4: When the latched peak is zero, no coefficient is kept, `map` is all zeros at the strobe, and no code is emitted.
- R5: Each code is 6 bits. Bit 5 is 1 when the coefficient is negative. Bits 4 to 0 are floor(32 × |c| / peak) whenever |c| is below the peak.
- R6: When |c| is greater than or equal to the peak, bits 4 to 0 saturate to 31.
- R7: Codes appear in increasing index order, each on a single-cycle `out_valid` pulse. The first pulse comes 5 cycles after `map_valid` and each later pulse 5 cycles after the previous one. `out_last` is high only with the final code of the frame.
- R8: While `busy` is high after the 48th beat, `in_valid`, `in_start` and `in_coef` have no effect on any output.
- R9: During and right after reset, `busy`, `map_valid`, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient beat valid |
| in_start | input | 1 | Marks index 0 of a frame |
| in_coef | input | 16 | Signed coefficient |
| in_thr | input | 16 | Threshold amplitude, sampled on the start beat |
| in_cmax | input | 16 | Frame peak amplitude, sampled on the start beat |
| busy | output | 1 | Frame in progress |
| map_valid | output | 1 | Position map and peak are valid |
| map | output | 48 | Kept-position bitmap, bit i for index i |
| cmax_out | output | 16 | Peak amplitude at full width |
| out_valid | output | 1 | Code valid |
| out_value | output | 6 | Sign and 5-bit normalized magnitude |
| out_last | output | 1 | Final code of the frame |

## Verification
The first frame is a mixed frame. It places coefficients exactly at the threshold and one below it, of both signs, which separates a greater-or-equal compare from a strict one and catches sign handling. An all-kept frame with a zero threshold and the full negative extreme exercises the 17-bit magnitude and the longest code stream. Input noise is driven throughout its division phase. Two empty frames tell apart the two discard causes: a threshold above any magnitude, and a zero peak. A small-peak frame with magnitudes around and beyond the peak separates truncating division from saturation.

// File: rtl/wcomp_pkg.sv
package wcomp_pkg;

    typedef enum logic [1:0] {
        WC_IDLE = 2'd0,
        WC_CAPT = 2'd1,
        WC_DIV  = 2'd2
    } wc_state_e;

    localparam int WC_DEF_N     = 48;
    localparam int WC_DEF_WIN   = 16;
    localparam int WC_DEF_WFRAC = 5;

endpackage

// File: rtl/wcomp_qualify.sv
module wcomp_qualify #(
    parameter int W_IN = 16
) (
    input  logic [W_IN-1:0] coef,
    input  logic [W_IN-1:0] thr,
    input  logic [W_IN-1:0] cmax,
    output logic [W_IN:0]   mag,
    output logic            neg,
    output logic            keep
);
    logic [W_IN:0] ext;

    always_comb begin
        ext  = {coef[W_IN-1], coef};
        neg  = coef[W_IN-1];
        mag  = neg ? (~ext + 1'b1) : ext;
        keep = (cmax != '0) && (mag >= {1'b0, thr});
    end
endmodule

// File: rtl/wcomp_divstep.sv
module wcomp_divstep #(
    parameter int RW = 18,
    parameter int DW = 16
) (
    input  logic [RW-1:0] rem_in,
    input  logic [DW-1:0] divisor,
    output logic [RW-1:0] rem_out,
    output logic          qbit
);
    logic [RW-1:0] shifted;
    logic [RW-1:0] dext;

    always_comb begin
        shifted = {rem_in[RW-2:0], 1'b0};
        dext    = RW'(divisor);
        qbit    = (shifted >= dext);
        rem_out = qbit ? (shifted - dext) : shifted;
    end
endmodule

// File: rtl/wcomp_top.sv
module wcomp_top
    import wcomp_pkg::*;
#(
    parameter int N_COEF = WC_DEF_N,
    parameter int W_IN   = WC_DEF_WIN,
    parameter int W_FRAC = WC_DEF_WFRAC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_start,
    input  logic [W_IN-1:0]     in_coef,
    input  logic [W_IN-1:0]     in_thr,
    input  logic [W_IN-1:0]     in_cmax,
    output logic                busy,
    output logic                map_valid,
    output logic [N_COEF-1:0]   map,
    output logic [W_IN-1:0]     cmax_out,
    output logic                out_valid,
    output logic [W_FRAC:0]     out_value,
    output logic                out_last
);
    localparam int IDXW = $clog2(N_COEF);
    localparam int CNTW = $clog2(N_COEF + 1);
    localparam int MAGW = W_IN + 1;
    localparam int REMW = MAGW + 1;
    localparam int STW  = (W_FRAC > 1) ? $clog2(W_FRAC) : 1;

    typedef struct packed {
        logic            neg;
        logic [MAGW-1:0] mag;
    } entry_t;

    typedef struct packed {
        wc_state_e                 st;
        logic [IDXW-1:0]           idx;
        logic [CNTW-1:0]           nk;
        logic [IDXW-1:0]           rd;
        logic [STW-1:0]            step;
        logic [W_IN-1:0]           thr;
        logic [W_IN-1:0]           cmax;
        logic [N_COEF-1:0]         map;
        logic [N_COEF-1:0][MAGW:0] kbuf;
        logic [REMW-1:0]           rem;
        logic [W_FRAC-1:0]         quo;
        logic                      sat;
        logic                      sgn;
        logic                      map_valid;
        logic                      out_valid;
        logic [W_FRAC:0]           out_value;
        logic                      out_last;
    } state_t;

    state_t s_q, s_d;

    logic [W_IN-1:0] cur_thr, cur_cmax;
    logic [MAGW-1:0] q_mag;
    logic            q_neg, q_keep;
    logic [REMW-1:0] rem_n;
    logic            qbit;

    assign cur_thr  = (s_q.st == WC_IDLE) ? in_thr  : s_q.thr;
    assign cur_cmax = (s_q.st == WC_IDLE) ? in_cmax : s_q.cmax;

    wcomp_qualify #(.W_IN(W_IN)) u_qual (
        .coef (in_coef),
        .thr  (cur_thr),
        .cmax (cur_cmax),
        .mag  (q_mag),
        .neg  (q_neg),
        .keep (q_keep)
    );

    wcomp_divstep #(.RW(REMW), .DW(W_IN)) u_div (
        .rem_in  (s_q.rem),
        .divisor (s_q.cmax),
        .rem_out (rem_n),
        .qbit    (qbit)
    );

    always_comb begin
        entry_t          ent;
        logic [IDXW-1:0] widx;
        logic [IDXW-1:0] nrd;
        logic            take;

        s_d           = s_q;
        s_d.map_valid = 1'b0;
        s_d.out_valid = 1'b0;
        s_d.out_last  = 1'b0;
        ent           = '0;
        nrd           = '0;
        take          = 1'b0;
        widx          = (s_q.st == WC_IDLE) ? '0 : s_q.idx;

        case (s_q.st)
            WC_IDLE: begin
                if (in_valid && in_start) begin
                    take     = 1'b1;
                    s_d.thr  = in_thr;
                    s_d.cmax = in_cmax;
                    s_d.map  = '0;
                    s_d.nk   = '0;
                    s_d.idx  = IDXW'(1);
                    s_d.st   = WC_CAPT;
                end
            end
            WC_CAPT: begin
                take = in_valid;
            end
            default: begin
                s_d.rem  = rem_n;
                s_d.quo  = {s_q.quo[W_FRAC-2:0], qbit};
                s_d.step = s_q.step + 1'b1;
                if (s_q.step == STW'(W_FRAC - 1)) begin
                    s_d.out_valid = 1'b1;
                    s_d.out_value = {s_q.sgn, s_q.sat ? {W_FRAC{1'b1}}
                                                      : {s_q.quo[W_FRAC-2:0], qbit}};
                    s_d.out_last  = (CNTW'(s_q.rd) == s_q.nk - 1'b1);
                    s_d.step      = '0;
                    s_d.quo       = '0;
                    if (s_d.out_last) begin
                        s_d.st = WC_IDLE;
                    end else begin
                        nrd       = s_q.rd + 1'b1;
                        s_d.rd    = nrd;
                        ent       = s_q.kbuf[nrd];
                        s_d.rem   = REMW'(ent.mag);
                        s_d.sgn   = ent.neg;
                        s_d.sat   = (ent.mag >= MAGW'(s_q.cmax));
                    end
                end
            end
        endcase

        if (take) begin
            if (q_keep) begin
                s_d.map[widx]                  = 1'b1;
                s_d.kbuf[s_d.nk[IDXW-1:0]]     = {q_neg, q_mag};
                s_d.nk                         = s_d.nk + 1'b1;
            end
            if (s_q.st == WC_CAPT) begin
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.idx == IDXW'(N_COEF - 1)) begin
                    s_d.map_valid = 1'b1;
                    s_d.rd        = '0;
                    s_d.step      = '0;
                    s_d.quo       = '0;
                    if (s_d.nk == '0) begin
                        s_d.st = WC_IDLE;
                    end else begin
                        s_d.st  = WC_DIV;
                        ent     = s_d.kbuf[0];
                        s_d.rem = REMW'(ent.mag);
                        s_d.sgn = ent.neg;
                        s_d.sat = (ent.mag >= MAGW'(s_q.cmax));
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= WC_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != WC_IDLE);
    assign map_valid = s_q.map_valid;
    assign map       = s_q.map;
    assign cmax_out  = s_q.cmax;
    assign out_valid = s_q.out_valid;
    assign out_value = s_q.out_value;
    assign out_last  = s_q.out_last;
endmodule

// File: rtl/wcomp_chk.sv
module wcomp_chk #(
    parameter int N_COEF = 48,
    parameter int W_IN   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              map_valid,
    input logic [N_COEF-1:0] map,
    input logic [W_IN-1:0]   cmax_out,
    input logic              out_valid,
    input logic              out_last
);
    localparam int CNTW = $clog2(N_COEF + 1);

    logic [N_COEF-1:0] seen_map;
    logic [CNTW-1:0]   seen_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_map <= '0;
            seen_cnt <= '0;
        end else if (map_valid) begin
            seen_map <= map;
            seen_cnt <= '0;
        end else if (out_valid) begin
            seen_cnt <= seen_cnt + 1'b1;
        end
    end

    a_r3_map_single: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |=> !map_valid);

    a_r4_zero_peak_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && cmax_out == '0) |-> (map == '0));

    a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r7_code_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r7_code_after_map: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !map_valid);

    a_r7_code_count: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (32'(seen_cnt) + 1 == $countones(seen_map)));

    a_r1_busy_mid_stream: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> busy);
endmodule

bind wcomp_top wcomp_chk #(.N_COEF(N_COEF), .W_IN(W_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .map_valid (map_valid),
    .map       (map),
    .cmax_out  (cmax_out),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/sim_wcomp_top.sv
module sim_wcomp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_start = 1'b0;
    logic [15:0] in_coef = '0;
    logic [15:0] in_thr = '0;
    logic [15:0] in_cmax = '0;
    logic        busy, map_valid, out_valid, out_last;
    logic [47:0] map;
    logic [15:0] cmax_out;
    logic [5:0]  out_value;

    wcomp_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_coef(in_coef), .in_thr(in_thr), .in_cmax(in_cmax), .busy(busy),
        .map_valid(map_valid), .map(map), .cmax_out(cmax_out),
        .out_valid(out_valid), .out_value(out_value), .out_last(out_last)
    );

    always #4 clk = ~clk;

    int          vecs = 0;
    int          errs = 0;
    int          cyc = 0;
    int          map_cyc = -1;
    int          next_cyc = -1;
    bit          mon_on = 0;
    logic [47:0] exp_map;
    logic [15:0] exp_cmax;
    logic [5:0]  vq[$];
    string       ftag = "";
    int unsigned seed = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference comparison on every falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            bit exp_mv, exp_ov;
            vecs++;
            exp_mv = (cyc == map_cyc);
            if (map_valid !== exp_mv) begin
                errs++;
                $display("FAIL R3 %s map_valid=%b expected %b at cycle %0d", ftag, map_valid, exp_mv, cyc);
            end else if (exp_mv) begin
                if (map !== exp_map) begin
                    errs++;
                    $display("FAIL R2 R3 %s map=%h expected %h", ftag, map, exp_map);
                end
                if (cmax_out !== exp_cmax) begin
                    errs++;
                    $display("FAIL R3 %s cmax_out=%h expected %h", ftag, cmax_out, exp_cmax);
                end
            end
            exp_ov = (vq.size() > 0) && (cyc == next_cyc);
            if (out_valid !== exp_ov) begin
                errs++;
                $display("FAIL R7 %s out_valid=%b expected %b at cycle %0d", ftag, out_valid, exp_ov, cyc);
            end else if (exp_ov) begin
                if (out_value !== vq[0]) begin
                    errs++;
                    $display("FAIL R5 R6 %s out_value=%h expected %h", ftag, out_value, vq[0]);
                end
                if (out_last !== (vq.size() == 1)) begin
                    errs++;
                    $display("FAIL R7 %s out_last=%b expected %b", ftag, out_last, vq.size() == 1);
                end
                void'(vq.pop_front());
                next_cyc = next_cyc + 5;
            end else if (out_last !== 1'b0) begin
                errs++;
                $display("FAIL R7 %s out_last=%b expected 0", ftag, out_last);
            end
        end
    end

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 8);
    endfunction

    function automatic int gen(int f, int i);
        int r = rnd();
        case (f)
            1: begin
                if (i == 0) return -20000;
                if (i == 5) return 1000;
                if (i == 6) return -1000;
                if (i == 7) return 999;
                if (i == 8) return -999;
                return (r % 40001) - 20000;
            end
            2: begin
                if (i == 3) return -32768;
                if (i == 4) return 32767;
                if (i == 5) return 0;
                return (r % 65536) - 32768;
            end
            5: begin
                if (i == 0) return 300;
                if (i == 1) return -299;
                if (i == 2) return 150;
                if (i == 3) return 99;
                if (i == 4) return 100;
                return (r % 801) - 400;
            end
            default: return (r % 60001) - 30000;
        endcase
    endfunction

    task automatic send_frame(int f, int thr, int cmax, bit noise, string tag);
        int c[48];
        for (int i = 0; i < 48; i++) c[i] = gen(f, i);
        @(negedge clk);
        while (busy) @(negedge clk);
        ftag = tag;
        for (int i = 0; i < 48; i++) begin
            if (i == 1) begin
                vecs++;
                if (busy !== 1'b1) begin
                    errs++;
                    $display("FAIL R1 %s busy=%b expected 1", tag, busy);
                end
            end
            in_valid = 1'b1;
            in_start = (i == 0);
            in_coef  = 16'(c[i]);
            in_thr   = (i == 0) ? 16'(thr) : 16'hDEAD;
            in_cmax  = (i == 0) ? 16'(cmax) : 16'h0001;
            if (i == 47) begin
                exp_map  = '0;
                exp_cmax = 16'(cmax);
                for (int k = 0; k < 48; k++) begin
                    int m = (c[k] < 0) ? -c[k] : c[k];
                    if (cmax != 0 && m >= thr) begin
                        int fr = (m >= cmax) ? 31 : (m * 32) / cmax;
                        exp_map[k] = 1'b1;
                        vq.push_back({(c[k] < 0) ? 1'b1 : 1'b0, 5'(fr)});
                    end
                end
                map_cyc  = cyc + 1;
                next_cyc = cyc + 6;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_start = 1'b0;
        // R8: stray beats while the codes are being produced
        while (busy) begin
            if (noise) begin
                in_valid = 1'b1;
                in_start = rnd() % 2 == 0;
                in_coef  = 16'(rnd());
                in_thr   = 16'h0000;
                in_cmax  = 16'h0001;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_start = 1'b0;
        repeat (3) @(negedge clk);
        vecs++;
        if (vq.size() != 0) begin
            errs++;
            $display("FAIL R7 %s pending codes=%0d expected 0", tag, vq.size());
        end
        vq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        vecs++;
        if ({busy, map_valid, out_valid, out_last} !== 4'b0000) begin
            errs++;
            $display("FAIL R9 in reset flags=%b expected 0000", {busy, map_valid, out_valid, out_last});
        end
        rst_n = 1'b1;
        @(negedge clk);
        vecs++;
        if ({busy, map_valid, out_valid, out_last} !== 4'b0000) begin
            errs++;
            $display("FAIL R9 after reset flags=%b expected 0000", {busy, map_valid, out_valid, out_last});
        end
        mon_on = 1;
        send_frame(1, 1000, 20000, 0, "R1 R2 mixed");
        send_frame(2, 0, 65535, 1, "R8 all-kept");
        send_frame(3, 40000, 5000, 0, "R2 none-kept");
        send_frame(4, 0, 0, 0, "R4 zero-peak");
        send_frame(5, 100, 300, 1, "R6 R8 saturate");
        send_frame(1, 1000, 20000, 0, "R1 R5 repeat");
        mon_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule